// File: doc/BRIEF.md
# Link Power-Status Interface Controller

This block watches the power-status level that a link-layer controller drives toward the physical layer. It uses that level to decide whether the link-side interface is live. The input is synchronized first. A counter then measures how long the input has stayed low, and two cycle thresholds sort the result into three graded conditions:

- normal operation;
- a low-power reset condition, in which the link-side control and data lines are held at zero and link requests are dropped, while the interface clock keeps running;
- a low-power disabled condition, in which the interface clock is also stopped.

The block sits between the physical-layer core and the link-side pins. Control, data and request values from the core pass through its registered gate. Its clock-enable output drives the interface clock. Its bus-reset request pulse goes to the arbitration logic. A return to normal after the deeper condition was reached by timing raises that pulse for one cycle. A return from the shallower condition does not. Repeater and cable logic never pass through this block.

Top module: `lps_if_ctrl`

## Requirements
- R1: A low on `lps_in` changes nothing unless it is seen for at least RST_CYCLES consecutive synchronized cycles. A low lasting RST_CYCLES-1 clock cycles or less leaves the interface in normal operation.
- R2: In the low-power reset condition, `ctl_out`, `data_out` and `lreq_out` are 0 whatever is applied to `ctl_in`, `data_in` and `lreq_in`, and `if_active` is 0.
- R3: In the low-power reset condition, `pclk_en` stays 1. The condition encoding is (`if_active`,`pclk_en`) = 1,1 for normal, 0,1 for reset and 0,0 for disabled.
- R4: A low held past DIS_CYCLES synchronized cycles (DIS_CYCLES > RST_CYCLES) moves the interface to disabled. There `pclk_en` is 0 and all gated outputs are 0.
- R5: After `lps_in` goes high from either the reset or the disabled condition, the interface is back in normal operation within four clock cycles.
- R6: While `rst` is high, and afterwards until `lps_in` is seen high, the interface is disabled. A return to normal that follows only a hardware reset raises no bus-reset request.
- R7: `bus_reset_req` is a pulse exactly one cycle wide. It is issued on the return to normal after the disable threshold was reached, and never on a return from the reset condition alone.
- R8: In normal operation, `ctl_out`, `data_out` and `lreq_out` equal the values `ctl_in`, `data_in` and `lreq_in` had at the previous rising clock edge, and `if_active` is 1 only in this condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lps_in | input | 1 | Link power-status level, asynchronous |
| lreq_in | input | 1 | Link request from the link side |
| ctl_in | input | CTL_W | Control value from the physical core |
| data_in | input | DATA_W | Data value from the physical core |
| lreq_out | output | 1 | Gated link request toward the core |
| ctl_out | output | CTL_W | Gated control toward the link |
| data_out | output | DATA_W | Gated data toward the link |
| pclk_en | output | 1 | Interface clock enable |
| if_active | output | 1 | High only in normal operation |
| bus_reset_req | output | 1 | One-cycle bus-reset request |

## Verification
The properties assume that `rst` is high from time zero until the first edges have loaded the output registers. They also assume that `lps_in` changes at most once per cycle. The bench drives every input on the falling edge and holds `rst` high for several cycles at the start, which keeps it inside both assumptions. Low periods are chosen with a margin of at least one cycle on each side of the synchronizer-plus-counter latency, so each check falls in a cycle where the condition is settled.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    LS_NORMAL   = 2'd0,
    LS_LPRESET  = 2'd1,
    LS_DISABLED = 2'd2
  } lps_state_t;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_sync
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lps_low_timer.sv
module lps_low_timer #(
  parameter int RST_CYCLES = 16,
  parameter int DIS_CYCLES = 64,
  localparam int CNT_W = $clog2(DIS_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic past_rst,
  output logic past_dis
);

  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(DIS_CYCLES);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] low_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || level)          low_cnt_q <= '0;
    else if (low_cnt_q != SAT_VAL) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign past_rst = (low_cnt_q >= RST_VAL);
  assign past_dis = (low_cnt_q >= SAT_VAL);

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       level,
  input  logic       past_rst,
  input  logic       past_dis,
  output lps_state_t state_nxt,
  output logic       bus_rst_pulse
);

  lps_state_t state_q;
  logic       timed_dis_q, timed_dis_nxt;
  logic       pulse_nxt;

  always_comb begin
    state_nxt     = state_q;
    timed_dis_nxt = timed_dis_q;
    pulse_nxt     = 1'b0;
    if (level) begin
      if (state_q != LS_NORMAL) begin
        state_nxt     = LS_NORMAL;
        pulse_nxt     = timed_dis_q;
        timed_dis_nxt = 1'b0;
      end
    end else if (past_dis) begin
      state_nxt     = LS_DISABLED;
      timed_dis_nxt = 1'b1;
    end else if (past_rst && state_q == LS_NORMAL) begin
      state_nxt = LS_LPRESET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= LS_DISABLED;
      timed_dis_q   <= 1'b0;
      bus_rst_pulse <= 1'b0;
    end else begin
      state_q       <= state_nxt;
      timed_dis_q   <= timed_dis_nxt;
      bus_rst_pulse <= pulse_nxt;
    end
  end

endmodule

// File: rtl/lps_if_ctrl.sv
module lps_if_ctrl
  import lps_pkg::*;
#(
  parameter int RST_CYCLES  = 16,
  parameter int DIS_CYCLES  = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CTL_W       = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lps_in,
  input  logic              lreq_in,
  input  logic [CTL_W-1:0]  ctl_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              lreq_out,
  output logic [CTL_W-1:0]  ctl_out,
  output logic [DATA_W-1:0] data_out,
  output logic              pclk_en,
  output logic              if_active,
  output logic              bus_reset_req
);

  logic       lps_s;
  logic       past_rst, past_dis;
  lps_state_t st_nxt;
  logic       live_nxt;

  lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_in   (lps_in),
    .d_sync (lps_s)
  );

  lps_low_timer #(
    .RST_CYCLES (RST_CYCLES),
    .DIS_CYCLES (DIS_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .level    (lps_s),
    .past_rst (past_rst),
    .past_dis (past_dis)
  );

  lps_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .level         (lps_s),
    .past_rst      (past_rst),
    .past_dis      (past_dis),
    .state_nxt     (st_nxt),
    .bus_rst_pulse (bus_reset_req)
  );

  assign live_nxt = (st_nxt == LS_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      lreq_out  <= 1'b0;
      ctl_out   <= '0;
      data_out  <= '0;
      pclk_en   <= 1'b0;
      if_active <= 1'b0;
    end else begin
      lreq_out  <= live_nxt & lreq_in;
      ctl_out   <= live_nxt ? ctl_in  : '0;
      data_out  <= live_nxt ? data_in : '0;
      pclk_en   <= (st_nxt != LS_DISABLED);
      if_active <= live_nxt;
    end
  end

endmodule

// File: rtl/lps_if_ctrl_chk.sv
module lps_if_ctrl_chk #(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lreq_out,
  input logic [CTL_W-1:0]  ctl_out,
  input logic [DATA_W-1:0] data_out,
  input logic              pclk_en,
  input logic              if_active,
  input logic              bus_reset_req
);

  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    bus_reset_req |=> !bus_reset_req);

  assert_pulse_on_return_R7: assert property (@(posedge clk) disable iff (rst)
    bus_reset_req |-> (if_active && !$past(pclk_en)));

  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !if_active |-> (ctl_out == '0 && data_out == '0 && !lreq_out));

  assert_clock_off_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !pclk_en |-> (ctl_out == '0 && data_out == '0 && !if_active));

  assert_active_has_clock_R3: assert property (@(posedge clk) disable iff (rst)
    if_active |-> pclk_en);

  assert_hw_reset_disables_R6: assert property (@(posedge clk)
    rst |=> (!pclk_en && !if_active && !bus_reset_req));

endmodule

bind lps_if_ctrl lps_if_ctrl_chk #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .lreq_out      (lreq_out),
  .ctl_out       (ctl_out),
  .data_out      (data_out),
  .pclk_en       (pclk_en),
  .if_active     (if_active),
  .bus_reset_req (bus_reset_req)
);

// File: tb/lps_if_ctrl_tb.sv
`timescale 1ns/1ps
module lps_if_ctrl_tb;

  localparam int RST_C  = 8;
  localparam int DIS_C  = 20;
  localparam int CTL_W  = 2;
  localparam int DATA_W = 8;
  localparam int VW     = 3 + CTL_W + DATA_W + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lps_in = 1'b0;
  logic lreq_in = 1'b0;
  logic [CTL_W-1:0]  ctl_in = '0;
  logic [DATA_W-1:0] data_in = '0;
  logic lreq_out, pclk_en, if_active, bus_reset_req;
  logic [CTL_W-1:0]  ctl_out;
  logic [DATA_W-1:0] data_out;

  always #2.5 clk = ~clk;

  lps_if_ctrl #(
    .RST_CYCLES (RST_C),
    .DIS_CYCLES (DIS_C),
    .CTL_W      (CTL_W),
    .DATA_W     (DATA_W)
  ) u_dut (
    .clk (clk), .rst (rst), .lps_in (lps_in), .lreq_in (lreq_in),
    .ctl_in (ctl_in), .data_in (data_in), .lreq_out (lreq_out),
    .ctl_out (ctl_out), .data_out (data_out), .pclk_en (pclk_en),
    .if_active (if_active), .bus_reset_req (bus_reset_req)
  );

  typedef struct {
    string          req;
    logic [VW-1:0]  exp;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int exp_pulses = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    #1;
    if (bus_reset_req === 1'b1) pulses++;
  end

  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        sb_item_t it;
        logic [VW-1:0] act;
        it  = sb_q.pop_front();
        act = {if_active, pclk_en, lreq_out, ctl_out, data_out, 8'(pulses)};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic act, input logic clk_on,
                            input logic pass);
    sb_item_t it;
    it.req = req;
    it.exp = {act, clk_on, pass & lreq_in, pass ? ctl_in : {CTL_W{1'b0}},
              pass ? data_in : {DATA_W{1'b0}}, 8'(exp_pulses)};
    sb_q.push_back(it);
    #0.1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    lreq_in = 1'b1; ctl_in = 2'b10; data_in = 8'hA5;
    step(3);
    expect_out("R6 disabled during reset", 0, 0, 0);
    @(negedge clk); rst = 1'b0;
    step(3);
    expect_out("R6 disabled after reset while low", 0, 0, 0);
    lps_in = 1'b1;
    step(4);
    expect_out("R6 R5 normal after reset, no bus reset", 1, 1, 1);
    ctl_in = 2'b01; data_in = 8'h3C;
    step(1);
    expect_out("R8 pass pattern 1", 1, 1, 1);
    ctl_in = 2'b11; data_in = 8'hFF; lreq_in = 1'b0;
    step(1);
    expect_out("R8 pass pattern 2", 1, 1, 1);
    lreq_in = 1'b1;
    lps_in = 1'b0;
    step(RST_C - 1);
    lps_in = 1'b1;
    expect_out("R1 short low during", 1, 1, 1);
    step(4);
    data_in = 8'h5A;
    step(1);
    expect_out("R1 short low after", 1, 1, 1);
    lps_in = 1'b0;
    step(RST_C + 4);
    expect_out("R2 R3 reset state gating", 0, 1, 0);
    lps_in = 1'b1;
    step(4);
    expect_out("R5 R7 back from reset, no pulse", 1, 1, 1);
    lps_in = 1'b0;
    step(RST_C + 4);
    expect_out("R2 reset before disable", 0, 1, 0);
    step(DIS_C - RST_C);
    expect_out("R4 disabled state", 0, 0, 0);
    lps_in = 1'b1;
    step(4);
    exp_pulses = 1;
    expect_out("R5 R7 back from disabled, one pulse", 1, 1, 1);
    ctl_in = 2'b00; data_in = 8'h81;
    step(1);
    expect_out("R8 pass pattern 3", 1, 1, 1);
    rst = 1'b1;
    step(1);
    expect_out("R6 reset from normal", 0, 0, 0);
    rst = 1'b0;
    step(4);
    expect_out("R6 R7 return after hw reset, no pulse", 1, 1, 1);
    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule